// File: doc/BRIEF.md
# Conversion Result Ready Flag Logic

This block sits between a periodic converter and the serial port that reads its results. It owns the result register and two flags that describe it. The ready flag (active low) says that an unread result is waiting. The steady flag says whether the published result comes from a fully settled filter. Each result update loads the register. If the reference is missing at that moment, the register is loaded with all ones instead of the converter word.

The ready flag is set high again only by a full-word read pulse from the serial interface. A warning strobe arrives a fixed number of master clocks before each update. When the current result is still unread at that warning, the flag is blanked high for the whole warning window. This tells the host not to start a transfer while the register is about to change. Reads that finish inside the window are ignored.

In fast-step mode the steady flag follows the filter's settled indication at every update. Outside that mode it falls at the first read and stays low. Any event that raises the ready flag also raises the steady flag, except a read.

Top module: `rdy_flag_ctrl`

## Requirements
- R1: During and after reset, `rdy` and `rdy_pin` are 1, `steady` is 1 and `res_word` is 0.
- R2: A clock edge with `upd_stb` high loads `res_word` and drives `rdy` to 0 from the next cycle on.
- R3: A clock edge with `word_rd` high, no `upd_stb` and no blanking window open sets `rdy` to 1 from the next cycle on.
- R4: A clock edge with `warn_stb` high while the result is unread opens a window. From the next cycle on, `rdy` and `steady` read 1 for exactly BLANK_CYC cycles. If no update ends the window, `rdy` then returns to 0.
- R5: A `warn_stb` while the result has already been read changes neither `rdy` nor `steady`.
- R6: With `fast_mode` = 1, an update sets `steady` to the inverse of `filt_settled`, and a read leaves `steady` unchanged.
- R7: With `fast_mode` = 0, a counted read clears `steady` to 0. An update leaves `steady` as it was, so later reads keep it at 0.
- R8: An update with `ref_missing` = 1 loads `res_word` with all ones, whatever `conv_word` holds.
- R9: A `word_rd` inside a blanking window has no effect: `rdy` stays 1, and `steady` is not cleared.
- R10: `rdy_pin` always equals `rdy`.
- R11: When `upd_stb` and `word_rd` fall on the same edge, the update wins and `rdy` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| upd_stb | input | 1 | One-cycle strobe: the converter publishes a new result |
| warn_stb | input | 1 | One-cycle strobe BLANK_CYC clocks ahead of `upd_stb` |
| word_rd | input | 1 | One-cycle pulse: the serial port has shifted out the whole result |
| fast_mode | input | 1 | Fast-step filter mode selected |
| filt_settled | input | 1 | The filter output is fully settled |
| ref_missing | input | 1 | The reference voltage is absent |
| conv_word | input | RES_W | Result word from the converter |
| rdy | output | 1 | Ready flag, 0 while an unread result waits |
| rdy_pin | output | 1 | Copy of `rdy` for the device pin |
| steady | output | 1 | 1 while the result is not from a settled filter |
| res_word | output | RES_W | Contents of the result register |

## Verification
Every flag and the result register change on the clock edge that samples the strobe. `res_word`, `rdy` and `steady` are therefore due one cycle after a strobe is driven. The window opened by a warning shows on `rdy` from the first cycle after the warning edge and lasts BLANK_CYC cycles. The bench drives each strobe at a falling edge and removes it at the next falling edge, then samples at that same falling edge, half a period after the register has updated. The window is checked at every falling edge of its length. The update that closes it is timed to land on the BLANK_CYC-th rising edge after the warning.

// File: rtl/rflag_pkg.sv
package rflag_pkg;

   typedef struct packed {
      logic ready;
      logic steady;
   } flag_pair_t;

   function automatic int cnt_bits(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/rflag_blank_timer.sv
module rflag_blank_timer #(
   parameter int BLANK_CYC = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic cancel,
   output logic active
);

   generate
      if (BLANK_CYC == 1) begin : g_single
         logic act_q;
         always_ff @(posedge clk) begin
            if (!rst_n)      act_q <= 1'b0;
            else if (cancel) act_q <= 1'b0;
            else             act_q <= start;
         end
         assign active = act_q;
      end else begin : g_count
         localparam int CW = rflag_pkg::cnt_bits(BLANK_CYC);
         localparam logic [CW-1:0] LOAD = CW'(BLANK_CYC);
         localparam logic [CW-1:0] ONE  = CW'(1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)               cnt_q <= '0;
            else if (cancel)          cnt_q <= '0;
            else if (start)           cnt_q <= LOAD;
            else if (cnt_q != '0)     cnt_q <= cnt_q - ONE;
         end
         assign active = (cnt_q != '0);
      end
   endgenerate

endmodule

// File: rtl/rflag_word_fill.sv
module rflag_word_fill #(
   parameter int RES_W = 24
) (
   input  logic [RES_W-1:0] raw,
   input  logic             no_ref,
   output logic [RES_W-1:0] word
);

   localparam logic [RES_W-1:0] ALL_ONES = {RES_W{1'b1}};

   always_comb begin
      word = no_ref ? ALL_ONES : raw;
   end

endmodule

// File: rtl/rflag_seq.sv
module rflag_seq (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   upd,
   input  logic                   rd,
   input  logic                   warn,
   input  logic                   fast,
   input  logic                   settled,
   input  logic                   blank,
   output rflag_pkg::flag_pair_t  flags,
   output logic                   blank_go
);

   logic rdy_q;
   logic stdy_q;
   logic read_ok;

   assign read_ok  = rd & ~blank;
   assign blank_go = warn & ~rdy_q & ~read_ok & ~upd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdy_q  <= 1'b1;
         stdy_q <= 1'b1;
      end else if (upd) begin
         rdy_q <= 1'b0;
         if (fast) stdy_q <= ~settled;
      end else if (read_ok) begin
         rdy_q <= 1'b1;
         if (!fast) stdy_q <= 1'b0;
      end else if (blank_go) begin
         stdy_q <= 1'b1;
      end
   end

   assign flags.ready  = rdy_q | blank;
   assign flags.steady = stdy_q;

endmodule

// File: rtl/rdy_flag_ctrl.sv
module rdy_flag_ctrl #(
   parameter int RES_W     = 24,
   parameter int BLANK_CYC = 100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd_stb,
   input  logic             warn_stb,
   input  logic             word_rd,
   input  logic             fast_mode,
   input  logic             filt_settled,
   input  logic             ref_missing,
   input  logic [RES_W-1:0] conv_word,
   output logic             rdy,
   output logic             rdy_pin,
   output logic             steady,
   output logic [RES_W-1:0] res_word
);

   if (RES_W < 1) begin : g_bad_width
      $error("rdy_flag_ctrl: RES_W must be at least 1");
   end
   if (BLANK_CYC < 1) begin : g_bad_blank
      $error("rdy_flag_ctrl: BLANK_CYC must be at least 1");
   end

   rflag_pkg::flag_pair_t flags;
   logic                  blank_act;
   logic                  blank_go;
   logic [RES_W-1:0]      fill_word;
   logic [RES_W-1:0]      res_q;

   rflag_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (blank_go),
      .cancel (upd_stb),
      .active (blank_act)
   );

   rflag_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd      (upd_stb),
      .rd       (word_rd),
      .warn     (warn_stb),
      .fast     (fast_mode),
      .settled  (filt_settled),
      .blank    (blank_act),
      .flags    (flags),
      .blank_go (blank_go)
   );

   rflag_word_fill #(.RES_W(RES_W)) u_fill (
      .raw    (conv_word),
      .no_ref (ref_missing),
      .word   (fill_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       res_q <= '0;
      else if (upd_stb) res_q <= fill_word;
   end

   assign res_word = res_q;
   assign rdy      = flags.ready;
   assign rdy_pin  = flags.ready;
   assign steady   = flags.steady;

endmodule

// File: rtl/rdy_flag_chk.sv
module rdy_flag_chk #(
   parameter int RES_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             upd_stb,
   input logic             warn_stb,
   input logic             word_rd,
   input logic             fast_mode,
   input logic             filt_settled,
   input logic             ref_missing,
   input logic [RES_W-1:0] conv_word,
   input logic             rdy,
   input logic             rdy_pin,
   input logic             steady,
   input logic [RES_W-1:0] res_word
);

   a_r2_update_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
      upd_stb |=> !rdy);

   a_r2_update_loads_word: assert property (@(posedge clk) disable iff (!rst_n)
      upd_stb && !ref_missing |=> res_word == $past(conv_word));

   a_r3_read_raises_ready: assert property (@(posedge clk) disable iff (!rst_n)
      word_rd && !rdy && !upd_stb |=> rdy);

   a_r4_warn_opens_window: assert property (@(posedge clk) disable iff (!rst_n)
      warn_stb && !rdy && !word_rd && !upd_stb |=> rdy && steady);

   a_r6_fast_steady: assert property (@(posedge clk) disable iff (!rst_n)
      upd_stb && fast_mode |=> steady == !$past(filt_settled));

   a_r7_read_clears_steady: assert property (@(posedge clk) disable iff (!rst_n)
      word_rd && !rdy && !fast_mode && !upd_stb |=> !steady);

   a_r8_noref_ones: assert property (@(posedge clk) disable iff (!rst_n)
      upd_stb && ref_missing |=> &res_word);

   a_r11_update_wins: assert property (@(posedge clk) disable iff (!rst_n)
      upd_stb && word_rd |=> !rdy_pin);

endmodule

bind rdy_flag_ctrl rdy_flag_chk #(.RES_W(RES_W)) u_rdy_flag_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .upd_stb      (upd_stb),
   .warn_stb     (warn_stb),
   .word_rd      (word_rd),
   .fast_mode    (fast_mode),
   .filt_settled (filt_settled),
   .ref_missing  (ref_missing),
   .conv_word    (conv_word),
   .rdy          (rdy),
   .rdy_pin      (rdy_pin),
   .steady       (steady),
   .res_word     (res_word)
);

// File: tb/rdy_flag_ctrl_bench.sv
module rdy_flag_ctrl_bench;

   localparam int RES_W     = 24;
   localparam int BLANK_CYC = 100;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             upd_stb = 1'b0;
   logic             warn_stb = 1'b0;
   logic             word_rd = 1'b0;
   logic             fast_mode = 1'b0;
   logic             filt_settled = 1'b0;
   logic             ref_missing = 1'b0;
   logic [RES_W-1:0] conv_word = '0;
   logic             rdy;
   logic             rdy_pin;
   logic             steady;
   logic [RES_W-1:0] res_word;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   rdy_flag_ctrl #(.RES_W(RES_W), .BLANK_CYC(BLANK_CYC)) u_rdy_flag_ctrl (
      .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .warn_stb(warn_stb),
      .word_rd(word_rd), .fast_mode(fast_mode), .filt_settled(filt_settled),
      .ref_missing(ref_missing), .conv_word(conv_word), .rdy(rdy),
      .rdy_pin(rdy_pin), .steady(steady), .res_word(res_word)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_flags(input string tag, input logic er, input logic es);
      check({tag, " rdy"}, 32'(rdy), 32'(er));
      check({tag, " steady"}, 32'(steady), 32'(es));
      check("R10 pin copy", 32'(rdy_pin), 32'(rdy));
   endtask

   // all drive tasks start at a falling edge and return at the next one
   task automatic do_upd(input logic [RES_W-1:0] w, input logic nr);
      conv_word = w; ref_missing = nr; upd_stb = 1'b1;
      @(negedge clk);
      upd_stb = 1'b0; ref_missing = 1'b0;
   endtask

   task automatic do_rd();
      word_rd = 1'b1;
      @(negedge clk);
      word_rd = 1'b0;
   endtask

   task automatic do_warn();
      warn_stb = 1'b1;
      @(negedge clk);
      warn_stb = 1'b0;
   endtask

   task automatic t_reset();
      check_flags("R1 reset", 1'b1, 1'b1);
      check("R1 reset word", 32'(res_word), 32'h0);
   endtask

   task automatic t_update_read();
      do_upd(24'h123456, 1'b0);
      check_flags("R2 R7 first update", 1'b0, 1'b1);
      check("R2 word load", 32'(res_word), 32'h123456);
      do_rd();
      check_flags("R3 R7 first read", 1'b1, 1'b0);
      do_upd(24'hABCDEF, 1'b0);
      check_flags("R7 update keeps steady low", 1'b0, 1'b0);
      check("R2 second word", 32'(res_word), 32'hABCDEF);
      do_rd();
      check_flags("R7 later read", 1'b1, 1'b0);
   endtask

   task automatic t_same_edge();
      word_rd = 1'b1;
      do_upd(24'h00F00F, 1'b0);
      word_rd = 1'b0;
      check_flags("R11 update beats read", 1'b0, 1'b0);
      check("R11 word", 32'(res_word), 32'h00F00F);
      do_rd();
      check_flags("R3 read after collision", 1'b1, 1'b0);
   endtask

   task automatic t_noref();
      do_upd(24'h000001, 1'b1);
      check("R8 all ones", 32'(res_word), 32'h00FFFFFF);
      check_flags("R8 flags", 1'b0, 1'b0);
      do_rd();
   endtask

   task automatic t_blank_update();
      int bad = 0;
      do_upd(24'h111111, 1'b0);
      do_warn();
      for (int i = 0; i < BLANK_CYC - 1; i++) begin
         if (rdy !== 1'b1 || steady !== 1'b1) bad++;
         if (i == 50) word_rd = 1'b1;
         if (i == 51) word_rd = 1'b0;
         @(negedge clk);
      end
      check("R4 R9 window held high, read ignored", 32'(bad), 32'h0);
      do_upd(24'h222222, 1'b0);
      check_flags("R4 update ends window", 1'b0, 1'b1);
      check("R2 word after window", 32'(res_word), 32'h222222);
      do_rd();
      check_flags("R7 read after window", 1'b1, 1'b0);
   endtask

   task automatic t_blank_expire();
      int bad = 0;
      do_upd(24'h333333, 1'b0);
      do_warn();
      for (int i = 0; i < BLANK_CYC; i++) begin
         if (rdy !== 1'b1) bad++;
         @(negedge clk);
      end
      check("R4 window length", 32'(bad), 32'h0);
      check_flags("R4 window closes unread", 1'b0, 1'b1);
      do_rd();
      check_flags("R3 read after expiry", 1'b1, 1'b0);
   endtask

   task automatic t_warn_after_read();
      do_warn();
      check_flags("R5 warn when read", 1'b1, 1'b0);
      repeat (5) @(negedge clk);
      check_flags("R5 still unchanged", 1'b1, 1'b0);
   endtask

   task automatic t_fast();
      fast_mode = 1'b1;
      filt_settled = 1'b0;
      do_upd(24'h444444, 1'b0);
      check_flags("R6 unsettled update", 1'b0, 1'b1);
      do_rd();
      check_flags("R6 read keeps steady", 1'b1, 1'b1);
      filt_settled = 1'b1;
      do_upd(24'h555555, 1'b0);
      check_flags("R6 settled update", 1'b0, 1'b0);
      do_rd();
      check_flags("R6 read after settle", 1'b1, 1'b0);
      fast_mode = 1'b0;
      filt_settled = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_update_read();
      t_same_edge();
      t_noref();
      t_blank_update();
      t_blank_expire();
      t_warn_after_read();
      t_fast();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog all requirements: actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule